// File: doc/BRIEF.md
# Line Address Generator with Line Doubling

This block walks a framebuffer for a raster display one display line at a time. At frame start it takes a base word address. On every display line it issues fetch requests of eight words each for the words of that line. The returned words go to the pixel output and are also written into a local line buffer. The pointer to the next line then moves forward by the line's word count plus a separate skip count. The logical line in memory can therefore be wider than the visible line. For example, a 512-pixel virtual canvas shown 320 truecolour pixels wide uses 320 words of width and 192 words of skip.

The word count of a line is derived from the visible pixel count and a colour-depth code. The count is the pixel count divided by 16, multiplied by the number of bit planes. In truecolour the count is one word per pixel. When line doubling is on, the lines alternate between fetched lines and replayed lines. A replayed line sends the previous line out again from the local buffer. It makes no memory request and does not move the pointer. Memory arbitration and palette lookup are outside this block.

Top module: `lag_top`

## Requirements
- R1: After reset, `req_valid` and `pix_valid` are low.
- R2: The line word count is (pix_count/16) × planes, where plane_code 0,1,2,3 select 1,2,4,8 planes. plane_code 4 or above selects truecolour, at one word per pixel. A fetched line issues ceil(words/8) requests, at the line address, then +8, +16 and so on.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged.
- R4: After each fetched display line, the next line address is the previous line address plus the line word count plus `line_skip`.
- R5: A `frame_start` pulse loads `base_addr` as the line address and resets the doubling phase. If `line_start` is asserted with `disp_en` in the same cycle, that line is fetched from `base_addr`.
- R6: With `double_en` high, the display lines after a frame start alternate fetch, replay, fetch, and so on. A replayed line issues no request. It outputs the previous fetched line's words in order, with `pix_replay` high.
- R7: A replayed line does not advance the line address.
- R8: On a fetched line, `pix_data` carries the returned words in order, with `pix_replay` low. Returned words beyond the line word count, from the tail of the last burst, are dropped.
- R9: A `line_start` pulse with `disp_en` low makes no request and no pixel output, and leaves the line address unchanged.
- R10: The fetched and buffered word count is limited to MAX_WORDS. The address step still uses the unlimited word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse at start of frame |
| line_start | input | 1 | Pulse at start of each raster line |
| disp_en | input | 1 | The current line is a display line |
| double_en | input | 1 | Line doubling enable |
| base_addr | input | ADDR_W | Frame base word address |
| pix_count | input | PIX_W | Visible pixels per line |
| plane_code | input | 3 | Colour-depth code (0..3: 1..8 planes, 4+: truecolour) |
| line_skip | input | SKIP_W | Extra words skipped after each line |
| req_valid | output | 1 | Burst request pending |
| req_addr | output | ADDR_W | Word address of the burst |
| req_ready | input | 1 | Memory accepts the burst |
| rd_valid | input | 1 | Returned word valid |
| rd_data | input | DATA_W | Returned word |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | DATA_W | Pixel word |
| pix_replay | output | 1 | Pixel word comes from the line buffer |

## Verification
Two events can fall in the same cycle: the frame restart, and the start of the first display line. When they coincide, the line address must come from the new base and not from the old pointer, and the doubling phase must restart on a fetch. The bench provokes this by pulsing `frame_start` and `line_start` together after another frame has left the pointer elsewhere. It then judges the first request address and the address of the following line. Burst stalls are also provoked, by toggling `req_ready` while a fetched line is in flight. The bench then checks that the issued addresses are unchanged.

// File: rtl/lag_pkg.sv
package lag_pkg;
  localparam int unsigned BURST_LEN = 8;

  // plane_code 0..3 -> 1,2,4,8 planes; 4 and above -> truecolour (16)
  function automatic int unsigned plane_count(input logic [2:0] code);
    return (code >= 3'd4) ? 16 : (32'd1 << code);
  endfunction

  function automatic int unsigned raw_words(input int unsigned pix, input logic [2:0] code);
    if (code >= 3'd4) return pix;
    return (pix >> 4) * plane_count(code);
  endfunction

  function automatic int unsigned clamp_words(input int unsigned w, input int unsigned lim);
    return (w > lim) ? lim : w;
  endfunction

  function automatic int unsigned burst_count(input int unsigned w);
    return (w + BURST_LEN - 1) / BURST_LEN;
  endfunction
endpackage

// File: rtl/lag_addr_gen.sv
module lag_addr_gen
  import lag_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PIX_W     = 12,
  parameter int SKIP_W    = 12,
  parameter int MAX_WORDS = 320,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1),
  localparam int BCNT_W   = $clog2(MAX_WORDS / BURST_LEN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              disp_en,
  input  logic              double_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PIX_W-1:0]  pix_count,
  input  logic [2:0]        plane_code,
  input  logic [SKIP_W-1:0] line_skip,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              fetch_go,
  output logic              replay_go,
  output logic [LEN_W-1:0]  line_len,
  output logic [ADDR_W-1:0] line_ptr
);
  logic [PIX_W-1:0]  words_raw;
  logic [BCNT_W-1:0] bursts_now;
  logic [BCNT_W-1:0] bursts_left;
  logic [ADDR_W-1:0] ptr, eff_ptr, burst_addr;
  logic              phase, eff_phase, line_go;

  assign words_raw  = PIX_W'(raw_words(32'(pix_count), plane_code));
  assign line_len   = LEN_W'(clamp_words(32'(words_raw), MAX_WORDS));
  assign bursts_now = BCNT_W'(burst_count(32'(line_len)));

  assign eff_ptr   = frame_start ? base_addr : ptr;
  assign eff_phase = frame_start ? 1'b0 : phase;
  assign line_go   = line_start & disp_en;
  assign replay_go = line_go & double_en & eff_phase;
  assign fetch_go  = line_go & ~replay_go;

  assign req_valid = (bursts_left != '0);
  assign req_addr  = burst_addr;
  assign line_ptr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr         <= '0;
      phase       <= 1'b0;
      burst_addr  <= '0;
      bursts_left <= '0;
    end else begin
      if (frame_start) begin
        ptr   <= base_addr;
        phase <= 1'b0;
      end
      if (line_go) phase <= double_en & ~eff_phase;
      if (fetch_go) begin
        ptr         <= eff_ptr + ADDR_W'(words_raw) + ADDR_W'(line_skip);
        burst_addr  <= eff_ptr;
        bursts_left <= bursts_now;
      end else if (replay_go) begin
        bursts_left <= '0;
      end else if (req_valid && req_ready) begin
        burst_addr  <= burst_addr + ADDR_W'(BURST_LEN);
        bursts_left <= bursts_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lag_line_buf.sv
module lag_line_buf #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 320,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              replay_go,
  input  logic [LEN_W-1:0]  line_len,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_replay
);
  logic [DATA_W-1:0] mem [MAX_WORDS];
  logic [LEN_W-1:0]  wr_cnt, wr_len, rp_cnt, rp_len;
  logic              wr_take, rp_take;

  assign wr_take = rd_valid && (wr_cnt < wr_len);
  assign rp_take = (rp_cnt < rp_len);

  always_ff @(posedge clk) begin
    if (wr_take) mem[IDX_W'(wr_cnt)] <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt     <= '0;
      wr_len     <= '0;
      rp_cnt     <= '0;
      rp_len     <= '0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_replay <= 1'b0;
    end else begin
      if (fetch_go) begin
        wr_cnt <= '0;
        wr_len <= line_len;
        rp_cnt <= '0;
        rp_len <= '0;
      end else if (replay_go) begin
        wr_cnt <= wr_len;
        rp_cnt <= '0;
        rp_len <= wr_len;
      end else begin
        if (wr_take) wr_cnt <= wr_cnt + 1'b1;
        if (rp_take) rp_cnt <= rp_cnt + 1'b1;
      end
      pix_valid  <= wr_take | rp_take;
      pix_data   <= wr_take ? rd_data : mem[IDX_W'(rp_cnt)];
      pix_replay <= rp_take & ~wr_take;
    end
  end
endmodule

// File: rtl/lag_top.sv
module lag_top #(
  parameter int ADDR_W    = 24,
  parameter int PIX_W     = 12,
  parameter int SKIP_W    = 12,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 320,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              disp_en,
  input  logic              double_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PIX_W-1:0]  pix_count,
  input  logic [2:0]        plane_code,
  input  logic [SKIP_W-1:0] line_skip,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_replay
);
  logic              fetch_go, replay_go;
  logic [LEN_W-1:0]  line_len;
  logic [ADDR_W-1:0] line_ptr;

  lag_addr_gen #(
    .ADDR_W(ADDR_W), .PIX_W(PIX_W), .SKIP_W(SKIP_W), .MAX_WORDS(MAX_WORDS)
  ) addr_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .disp_en(disp_en), .double_en(double_en), .base_addr(base_addr),
    .pix_count(pix_count), .plane_code(plane_code), .line_skip(line_skip),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .fetch_go(fetch_go), .replay_go(replay_go), .line_len(line_len),
    .line_ptr(line_ptr)
  );

  lag_line_buf #(
    .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)
  ) buf_i (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .replay_go(replay_go),
    .line_len(line_len), .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_replay(pix_replay)
  );
endmodule

// File: rtl/lag_checker.sv
module lag_checker #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              disp_en,
  input logic [ADDR_W-1:0] base_addr,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              pix_valid,
  input logic              pix_replay,
  input logic              replay_go,
  input logic [LEN_W-1:0]  line_len,
  input logic [ADDR_W-1:0] line_ptr
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!req_valid && !pix_valid));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !line_start) |=> (req_valid && $stable(req_addr)));

  a_r5_frame_base: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start && disp_en && line_len != '0) |=>
      (req_valid && req_addr == $past(base_addr)));

  a_r6_replay_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    replay_go |=> !req_valid);

  a_r7_replay_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_go && !frame_start) |=> $stable(line_ptr));

  a_r8_fetch_from_return: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_replay) |-> $past(rd_valid));
endmodule

bind lag_top lag_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .disp_en(disp_en), .base_addr(base_addr), .req_valid(req_valid),
  .req_addr(req_addr), .req_ready(req_ready), .rd_valid(rd_valid),
  .pix_valid(pix_valid), .pix_replay(pix_replay), .replay_go(replay_go),
  .line_len(line_len), .line_ptr(line_ptr)
);

// File: tb/lag_top_tb_top.sv
module lag_top_tb_top;
  localparam int ADDR_W = 24, PIX_W = 12, SKIP_W = 12, DATA_W = 16, MAXW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, line_start = 0, disp_en = 0, double_en = 0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [PIX_W-1:0]  pix_count = '0;
  logic [2:0]        plane_code = '0;
  logic [SKIP_W-1:0] line_skip = '0;
  logic              req_valid, req_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr;
  logic              rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic              pix_valid, pix_replay;
  logic [DATA_W-1:0] pix_data;

  int checks = 0, failures = 0;
  bit stall = 0;
  int reqs [256];
  logic [DATA_W-1:0] caps [256];
  int capsrc [256];
  int nreq = 0, ncap = 0;
  int pend [$];
  int cur = 0, beat = 0;

  always #5 clk = ~clk;

  lag_top #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .SKIP_W(SKIP_W), .DATA_W(DATA_W),
            .MAX_WORDS(MAXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .disp_en(disp_en), .double_en(double_en), .base_addr(base_addr),
    .pix_count(pix_count), .plane_code(plane_code), .line_skip(line_skip),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_replay(pix_replay)
  );

  function automatic logic [DATA_W-1:0] mem_word(input int a);
    return DATA_W'(a * 5 + 32'h1234);
  endfunction

  // memory model: 8 words returned per accepted burst, one per cycle
  always @(posedge clk) begin
    if (req_valid && req_ready) pend.push_back(int'(req_addr));
    if (beat == 0 && pend.size() > 0) begin cur = pend.pop_front(); beat = 8; end
    if (beat > 0) begin
      rd_valid <= 1'b1;
      rd_data  <= mem_word(cur + 8 - beat);
      beat = beat - 1;
    end else rd_valid <= 1'b0;
  end

  // capture, then drive ready for the next cycle
  always @(negedge clk) begin
    if (req_valid && req_ready && nreq < 256) begin reqs[nreq] = int'(req_addr); nreq++; end
    if (pix_valid && ncap < 256) begin caps[ncap] = pix_data; capsrc[ncap] = int'(pix_replay); ncap++; end
    req_ready <= stall ? ~req_ready : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic frame(input int base);
    @(negedge clk); base_addr = ADDR_W'(base); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  // one display line; with_frame pulses frame_start in the same cycle
  task automatic run_line(input int exp_addr, input int words, input bit replay,
                          input bit with_frame, input int base, input string req);
    int bad, first_a, first_e, nb;
    nreq = 0; ncap = 0;
    @(negedge clk);
    if (with_frame) begin base_addr = ADDR_W'(base); frame_start = 1; end
    line_start = 1; disp_en = 1;
    @(negedge clk); line_start = 0; frame_start = 0;
    repeat (300) @(negedge clk);
    nb = replay ? 0 : (words + 7) / 8;
    check(nreq == nb, req, "request count", nreq, nb);
    bad = 0; first_a = 0; first_e = 0;
    for (int k = 0; k < nreq && k < nb; k++)
      if (reqs[k] != exp_addr + 8 * k && bad++ == 0) begin first_a = reqs[k]; first_e = exp_addr + 8 * k; end
    check(bad == 0, req, "request address", first_a, first_e);
    check(ncap == words, req, "pixel word count", ncap, words);
    bad = 0;
    for (int i = 0; i < ncap && i < words; i++)
      if ((caps[i] != mem_word(exp_addr + i) || capsrc[i] != int'(replay)) && bad++ == 0) begin
        first_a = int'(caps[i]); first_e = int'(mem_word(exp_addr + i));
      end
    check(bad == 0, req, "pixel data/source", first_a, first_e);
  endtask

  task automatic t_reset;
    check(!req_valid, "R1", "req_valid after reset", int'(req_valid), 0);
    check(!pix_valid, "R1", "pix_valid after reset", int'(pix_valid), 0);
  endtask

  task automatic t_plain;   // R2 R4 R8: 320 px, 1 plane -> 20 words, 3 bursts
    double_en = 0; pix_count = 320; plane_code = 0; line_skip = 12;
    frame(32'h1000);
    run_line(32'h1000, 20, 0, 0, 0, "R2");
    run_line(32'h1000 + 32, 20, 0, 0, 0, "R4");
    run_line(32'h1000 + 64, 20, 0, 0, 0, "R8");
  endtask

  task automatic t_same_cycle;  // R5: frame and line start together
    pix_count = 128; plane_code = 2; line_skip = 0;  // 32 words
    run_line(32'h2000, 32, 0, 1, 32'h2000, "R5");
    run_line(32'h2020, 32, 0, 0, 0, "R5");
  endtask

  task automatic t_depths;  // R2 other depths, R3 stalls
    stall = 1;
    pix_count = 20; plane_code = 4; line_skip = 4;
    frame(32'h4000);
    run_line(32'h4000, 20, 0, 0, 0, "R3");
    pix_count = 64; plane_code = 3;               // 32 words
    run_line(32'h4000 + 24, 32, 0, 0, 0, "R2");
    pix_count = 256; plane_code = 1;              // 32 words
    run_line(32'h4000 + 60, 32, 0, 0, 0, "R2");
    stall = 0;
  endtask

  task automatic t_double;  // R6 R7: 128 px 1 plane -> 8 words, skip 8
    double_en = 1; pix_count = 128; plane_code = 0; line_skip = 8;
    frame(32'h3000);
    run_line(32'h3000, 8, 0, 0, 0, "R6");
    run_line(32'h3000, 8, 1, 0, 0, "R6");
    run_line(32'h3010, 8, 0, 0, 0, "R7");
    run_line(32'h3010, 8, 1, 0, 0, "R7");
    run_line(32'h3020, 8, 0, 0, 0, "R7");
    double_en = 0;
  endtask

  task automatic t_disp_off;  // R9
    pix_count = 128; plane_code = 0; line_skip = 0;
    frame(32'h5000);
    nreq = 0; ncap = 0;
    @(negedge clk); disp_en = 0; line_start = 1;
    @(negedge clk); line_start = 0;
    repeat (60) @(negedge clk);
    check(nreq == 0, "R9", "requests on blank line", nreq, 0);
    check(ncap == 0, "R9", "pixels on blank line", ncap, 0);
    run_line(32'h5000, 8, 0, 0, 0, "R9");
  endtask

  task automatic t_clamp;  // R10: 100 truecolour words, limited to 64
    pix_count = 100; plane_code = 4; line_skip = 28;
    frame(32'h6000);
    run_line(32'h6000, 64, 0, 0, 0, "R10");
    run_line(32'h6000 + 128, 64, 0, 0, 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_same_cycle();
    t_depths();
    t_double();
    t_disp_off();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule